// File: doc/BRIEF.md
# Accumulator Execute Unit with Status Flags

This block is the execute stage of a small accumulator processor with 14-bit instructions. In every clock cycle it takes the working register value, the operand already read from the register file, the current zero, digit-carry and carry flags, a bank-select bit and the instruction word. It computes the 8-bit result and decides whether the result goes back to the working register or to the register file. It also produces the new flag values and a skip request for conditional instructions. All outputs are registered, so each result appears one clock after its instruction is presented.

The unit covers add and subtract, with a literal or with a file operand. It also does AND, inclusive OR, exclusive OR, complement, increment and decrement (each with or without skip-on-zero), move, rotate through carry, nibble swap, single-bit clear, set and test, clear, and literal load. Branches and control instructions pass through with no effect. The one undefined code range raises an error pulse and leaves the result and the flags untouched. Instruction fetch and the register file itself sit outside the block. The block drives the file address, which is the bank bit joined above the 7-bit address field of the instruction.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero at that edge.
- R2: Add (file form `000111dfffffff`, literal form `11111xkkkkkkkk`) gives operand+W modulo 256. Carry is the carry out of bit 7 and digit carry is the carry out of bit 3. Zero is set when the result is 0.
- R3: Subtract (file form `000010dfffffff` computes file−W; literal form `11110xkkkkkkkk` computes literal−W) gives the difference modulo 256. Carry is 1 when the minuend is not below W. Digit carry is 1 when the minuend's low nibble is not below W's low nibble. Zero is set when the result is 0.
- R4: AND (`000101`/`111001`), inclusive OR (`000100`/`111000`), exclusive OR (`000110`/`111010`), complement (`001001`), increment (`001010`), decrement (`000011`) and move (`001000`) update only the zero flag. Carry and digit carry keep their input values.
- R5: Rotate left (`001101`) shifts carry into bit 0 and bit 7 into carry. Rotate right (`001100`) shifts carry into bit 7 and bit 0 into carry. Zero and digit carry keep their input values.
- R6: Swap (`001110`) exchanges the nibbles. Bit clear (`0100bbb`) and bit set (`0101bbb`) change the bit numbered by instruction bits 9:7 and write the file. None of these three alters any flag.
- R7: For byte operations on the file, instruction bit 7 = 1 writes the file and 0 writes W. Literal operations always write W. In every cycle `faddr_q` = {`bank_in`, instruction bits 6:0}.
- R8: Clear (`000001d`) produces 0 into the destination chosen by bit 7 and forces zero to 1, whatever its input.
- R9: Bit test (`0110bbb` skip-if-clear, `0111bbb` skip-if-set) raises `skip_q` when the condition holds. It writes nothing, keeps the result and changes no flag.
- R10: Increment-skip (`001111`) and decrement-skip (`001011`) write the incremented or decremented value, raise `skip_q` when that value is 0, and change no flag.
- R11: Literal load (`11000x`, `11010x` in bits 13:8) writes the literal to W. Move-to-file (`0000001fffffff`) writes W to the file. Neither changes a flag. Codes with bits 13:7 all zero, and codes `10xxxxxxxxxxxx`, write nothing and keep the result and the flags.
- R12: An undefined code (`111011` in bits 13:8) raises `bad_op_q` for exactly that cycle. It writes nothing, keeps `res_q`, and passes the input flags through unchanged.
- R13: Outputs change only at the clock edge that follows the instruction, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| file_in | input | 8 | Operand read from the register file |
| bank_in | input | 1 | Direct bank select bit |
| z_in | input | 1 | Current zero flag |
| dc_in | input | 1 | Current digit-carry flag |
| c_in | input | 1 | Current carry flag |
| res_q | output | 8 | Result value |
| wr_w_q | output | 1 | Result goes to W |
| wr_f_q | output | 1 | Result goes to the register file |
| faddr_q | output | 8 | File address: bank bit over 7-bit field |
| z_q | output | 1 | New zero flag |
| dc_q | output | 1 | New digit-carry flag |
| c_q | output | 1 | New carry flag |
| skip_q | output | 1 | Skip the next instruction |
| bad_op_q | output | 1 | Undefined instruction pulse |

## Verification
The hardest situations to reach are the nibble borrow boundaries of subtraction. There, digit carry and carry disagree, for example when the low nibble borrows but the whole byte does not. The stimulus sweeps every minuend against W stepped across its whole range in both file and literal forms, so every nibble and byte borrow combination appears. The undefined-code hold is reached by issuing a known result first and then the bad code with flag inputs set opposite to what an arithmetic operation would give. The bench then confirms that the result register and the flags did not move.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_IOR, K_XOR, K_COM, K_INC, K_DEC, K_MOV,
    K_RL, K_RR, K_SWAP, K_BCLR, K_BSET, K_TSTC, K_TSTS, K_INCSZ, K_DECSZ,
    K_CLR, K_MOVWF, K_LDK, K_BAD
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      lit;      // operand A is the literal field
    logic      to_file;  // destination is the register file
  } alu_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int IW = 14
) (
  input  logic [IW-1:0] op,
  output alu_ctl_t      ctl
);
  always_comb begin
    ctl.kind    = K_NONE;
    ctl.lit     = 1'b0;
    ctl.to_file = op[7];
    casez (op[13:8])
      6'b000000: begin ctl.kind = op[7] ? K_MOVWF : K_NONE; end
      6'b000001: ctl.kind = K_CLR;
      6'b000010: ctl.kind = K_SUB;
      6'b000011: ctl.kind = K_DEC;
      6'b000100: ctl.kind = K_IOR;
      6'b000101: ctl.kind = K_AND;
      6'b000110: ctl.kind = K_XOR;
      6'b000111: ctl.kind = K_ADD;
      6'b001000: ctl.kind = K_MOV;
      6'b001001: ctl.kind = K_COM;
      6'b001010: ctl.kind = K_INC;
      6'b001011: ctl.kind = K_DECSZ;
      6'b001100: ctl.kind = K_RR;
      6'b001101: ctl.kind = K_RL;
      6'b001110: ctl.kind = K_SWAP;
      6'b001111: ctl.kind = K_INCSZ;
      6'b0100??: begin ctl.kind = K_BCLR; ctl.to_file = 1'b1; end
      6'b0101??: begin ctl.kind = K_BSET; ctl.to_file = 1'b1; end
      6'b0110??: begin ctl.kind = K_TSTC; ctl.to_file = 1'b0; end
      6'b0111??: begin ctl.kind = K_TSTS; ctl.to_file = 1'b0; end
      6'b10????: begin ctl.kind = K_NONE; ctl.to_file = 1'b0; end
      6'b110???: begin ctl.kind = K_LDK; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      6'b111000: begin ctl.kind = K_IOR; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      6'b111001: begin ctl.kind = K_AND; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      6'b111010: begin ctl.kind = K_XOR; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      6'b111011: begin ctl.kind = K_BAD; ctl.to_file = 1'b0; end
      6'b11110?: begin ctl.kind = K_SUB; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      6'b11111?: begin ctl.kind = K_ADD; ctl.lit = 1'b1; ctl.to_file = 1'b0; end
      default:   ctl.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hcout
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic [DW:0]   full;
  logic [HW:0]   half;

  // Subtraction is a + ~b + 1, so the carry outputs are inverted borrows.
  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + (DW+1)'(sub);
  assign half  = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + (HW+1)'(sub);
  assign sum   = full[DW-1:0];
  assign cout  = full[DW];
  assign hcout = half[HW];
endmodule

// File: rtl/acc_alu_bitsel.sv
module acc_alu_bitsel #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic [BW-1:0] sel,
  output logic [DW-1:0] mask
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign mask[i] = (sel == BW'(i));
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,   // data width; literal field is opcode[DW-1:0]
  parameter int IW = 14,  // instruction width
  parameter int FW = 7    // file address field width
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] opcode,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] file_in,
  input  logic          bank_in,
  input  logic          z_in,
  input  logic          dc_in,
  input  logic          c_in,
  output logic [DW-1:0] res_q,
  output logic          wr_w_q,
  output logic          wr_f_q,
  output logic [FW:0]   faddr_q,
  output logic          z_q,
  output logic          dc_q,
  output logic          c_q,
  output logic          skip_q,
  output logic          bad_op_q
);
  localparam int HW = DW / 2;
  localparam int BW = $clog2(DW);

  alu_ctl_t      ctl;
  logic [DW-1:0] opa, sum, mask;
  logic          cout, hcout;

  logic [DW-1:0] n_res;
  logic          n_ww, n_wf, n_z, n_dc, n_c, n_skip, n_bad, n_wr;

  acc_alu_decode #(.IW(IW)) u_dec (.op(opcode), .ctl(ctl));

  assign opa = ctl.lit ? opcode[DW-1:0] : file_in;

  acc_alu_addsub #(.DW(DW)) u_add (
    .a(opa), .b(w_in), .sub(ctl.kind == K_SUB),
    .sum(sum), .cout(cout), .hcout(hcout)
  );

  acc_alu_bitsel #(.DW(DW)) u_bit (.sel(opcode[7 +: BW]), .mask(mask));

  always_comb begin
    n_res  = res_q;
    n_wr   = 1'b1;
    n_z    = z_in;
    n_dc   = dc_in;
    n_c    = c_in;
    n_skip = 1'b0;
    n_bad  = 1'b0;
    unique case (ctl.kind)
      K_ADD, K_SUB: begin n_res = sum; n_z = (sum == '0); n_c = cout; n_dc = hcout; end
      K_AND:   begin n_res = opa & w_in; n_z = (n_res == '0); end
      K_IOR:   begin n_res = opa | w_in; n_z = (n_res == '0); end
      K_XOR:   begin n_res = opa ^ w_in; n_z = (n_res == '0); end
      K_COM:   begin n_res = ~file_in;   n_z = (n_res == '0); end
      K_INC:   begin n_res = file_in + 1'b1; n_z = (n_res == '0); end
      K_DEC:   begin n_res = file_in - 1'b1; n_z = (n_res == '0); end
      K_MOV:   begin n_res = file_in;    n_z = (n_res == '0); end
      K_RL:    {n_c, n_res} = {file_in, c_in};
      K_RR:    {n_res, n_c} = {c_in, file_in};
      K_SWAP:  n_res = {file_in[HW-1:0], file_in[DW-1:HW]};
      K_BCLR:  n_res = file_in & ~mask;
      K_BSET:  n_res = file_in | mask;
      K_TSTC:  begin n_wr = 1'b0; n_skip = ((file_in & mask) == '0); end
      K_TSTS:  begin n_wr = 1'b0; n_skip = ((file_in & mask) != '0); end
      K_INCSZ: begin n_res = file_in + 1'b1; n_skip = (n_res == '0); end
      K_DECSZ: begin n_res = file_in - 1'b1; n_skip = (n_res == '0); end
      K_CLR:   begin n_res = '0; n_z = 1'b1; end
      K_MOVWF: n_res = w_in;
      K_LDK:   n_res = opcode[DW-1:0];
      K_BAD:   begin n_wr = 1'b0; n_bad = 1'b1; end
      default: n_wr = 1'b0;
    endcase
    n_wf = n_wr & ctl.to_file;
    n_ww = n_wr & ~ctl.to_file;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0; wr_w_q <= 1'b0; wr_f_q <= 1'b0; faddr_q <= '0;
      z_q <= 1'b0; dc_q <= 1'b0; c_q <= 1'b0; skip_q <= 1'b0; bad_op_q <= 1'b0;
    end else begin
      res_q    <= n_res;
      wr_w_q   <= n_ww;
      wr_f_q   <= n_wf;
      faddr_q  <= {bank_in, opcode[FW-1:0]};
      z_q      <= n_z;
      dc_q     <= n_dc;
      c_q      <= n_c;
      skip_q   <= n_skip;
      bad_op_q <= n_bad;
    end
  end

  // R3: file-minus-W carry is the absence of a borrow
  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.kind == K_SUB && !ctl.lit) |=> (c_q == ($past(file_in) >= $past(w_in))));

  // R5: rotates leave zero alone
  p_rot_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.kind == K_RL || ctl.kind == K_RR) |=> (z_q == $past(z_in)));

  // R8: clear forces zero flag and a zero result
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.kind == K_CLR) |=> (z_q && res_q == '0));

  // R9: bit tests write nothing
  p_test_nowr_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl.kind == K_TSTC || ctl.kind == K_TSTS) |=> (!wr_w_q && !wr_f_q && $stable(res_q)));

  // R12: undefined code holds the result and writes nothing
  p_bad_hold_r12: assert property (@(posedge clk) disable iff (rst)
    bad_op_q |-> (!wr_w_q && !wr_f_q && res_q == $past(res_q)));

  // R7: never both destinations
  p_one_dest_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_w_q, wr_f_q}));
endmodule

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] opcode = '0;
  logic [7:0]  w_in = '0, file_in = '0;
  logic        bank_in = 1'b0, z_in = 1'b0, dc_in = 1'b0, c_in = 1'b0;
  logic [7:0]  res_q, faddr_q;
  logic        wr_w_q, wr_f_q, z_q, dc_q, c_q, skip_q, bad_op_q;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] last_res = '0;

  always #10 clk = ~clk;

  acc_exec_unit u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .w_in(w_in), .file_in(file_in),
    .bank_in(bank_in), .z_in(z_in), .dc_in(dc_in), .c_in(c_in),
    .res_q(res_q), .wr_w_q(wr_w_q), .wr_f_q(wr_f_q), .faddr_q(faddr_q),
    .z_q(z_q), .dc_q(dc_q), .c_q(c_q), .skip_q(skip_q), .bad_op_q(bad_op_q)
  );

  // drive at a falling edge, return at the next falling edge
  task automatic run(input logic [13:0] op, input logic [7:0] w, input logic [7:0] f,
                     input logic zi, input logic dci, input logic ci, input logic bk);
    opcode = op; w_in = w; file_in = f; z_in = zi; dc_in = dci; c_in = ci; bank_in = bk;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] er, input logic eww, input logic ewf,
                     input logic ez, input logic edc, input logic ec, input logic esk,
                     input logic ebad, input logic [7:0] efa);
    logic [16:0] act, exp;
    act = {res_q, wr_w_q, wr_f_q, z_q, dc_q, c_q, skip_q, bad_op_q, faddr_q[7:6]};
    exp = {er, eww, ewf, ez, edc, ec, esk, ebad, efa[7:6]};
    checks++;
    if (act !== exp || faddr_q !== efa) begin
      failures++;
      $display("FAIL %s op=%h: actual res=%h ww=%b wf=%b z=%b dc=%b c=%b sk=%b bad=%b fa=%h expected res=%h ww=%b wf=%b z=%b dc=%b c=%b sk=%b bad=%b fa=%h",
               tag, opcode, res_q, wr_w_q, wr_f_q, z_q, dc_q, c_q, skip_q, bad_op_q, faddr_q,
               er, eww, ewf, ez, edc, ec, esk, ebad, efa);
    end
    last_res = er;
  endtask

  function automatic logic [7:0] fa(input logic bk, input logic [13:0] op);
    return {bk, op[6:0]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] op;
    logic [8:0]  s;
    logic [7:0]  r, w, k;
    logic        d, bk;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 8'h00, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    rst = 1'b0;

    // R2: add, file form sweep and literal form sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        d = a[0]; bk = a[1];
        op = {6'b000111, d, 7'(a * 3)};
        run(op, 8'(b), 8'(a), b[0], b[1], b[2], bk);
        s = 9'(a) + 9'(b);
        chk("R2 addwf", s[7:0], !d, d, s[7:0] == 0, (a % 16 + b % 16) > 15, s[8], 0, 0, fa(bk, op));
        op = {6'b11111, a[2], 8'(a)};
        run(op, 8'(b), 8'(b * 7), b[2], b[0], b[1], 1'b0);
        chk("R2 addlw", s[7:0], 1, 0, s[7:0] == 0, (a % 16 + b % 16) > 15, s[8], 0, 0, fa(0, op));
      end
    end

    // R3: subtract, inverted borrows
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        d = a[1]; r = 8'(a - b);
        op = {6'b000010, d, 7'(a)};
        run(op, 8'(b), 8'(a), ~b[0], b[1], ~b[2], b[3]);
        chk("R3 subwf", r, !d, d, r == 0, (a % 16) >= (b % 16), a >= b, 0, 0, fa(b[3], op));
        op = {6'b11110, a[0], 8'(a)};
        run(op, 8'(b), 8'(~a), b[0], ~b[1], b[2], 1'b1);
        chk("R3 sublw", r, 1, 0, r == 0, (a % 16) >= (b % 16), a >= b, 0, 0, fa(1, op));
      end
    end

    // R4: logic, complement, inc, dec, move update only zero
    for (int a = 0; a < 256; a++) begin
      w = 8'(a * 37 + 11); d = a[2];
      run({6'b000101, d, 7'h11}, w, 8'(a), ~a[0], a[3], a[4], 0);
      r = 8'(a) & w; chk("R4 andwf", r, !d, d, r == 0, a[3], a[4], 0, 0, 8'h11);
      run({6'b111000, 8'(a)}, w, 8'h00, a[0], a[4], a[3], 0);
      r = 8'(a) | w; chk("R4 iorlw", r, 1, 0, r == 0, a[4], a[3], 0, 0, fa(0, {6'b111000, 8'(a)}));
      run({6'b000110, d, 7'h05}, w, 8'(a), 1'b1, a[5], a[6], 0);
      r = 8'(a) ^ w; chk("R4 xorwf", r, !d, d, r == 0, a[5], a[6], 0, 0, 8'h05);
      run({6'b111010, 8'(a)}, 8'(a), 8'h00, 1'b0, a[1], a[0], 0);
      chk("R4 xorlw zero", 8'h00, 1, 0, 1, a[1], a[0], 0, 0, fa(0, {6'b111010, 8'(a)}));
      run({6'b111001, 8'(a)}, w, 8'h00, a[0], a[1], a[2], 0);
      r = 8'(a) & w; chk("R4 andlw", r, 1, 0, r == 0, a[1], a[2], 0, 0, fa(0, {6'b111001, 8'(a)}));
      run({6'b001001, d, 7'h20}, w, 8'(a), a[0], ~a[1], a[2], 0);
      r = ~8'(a); chk("R4 comf", r, !d, d, r == 0, ~a[1], a[2], 0, 0, 8'h20);
      run({6'b001010, d, 7'h21}, w, 8'(a), ~a[0], a[1], ~a[2], 0);
      r = 8'(a + 1); chk("R4 incf", r, !d, d, r == 0, a[1], ~a[2], 0, 0, 8'h21);
      run({6'b000011, d, 7'h22}, w, 8'(a), a[0], a[6], a[7], 0);
      r = 8'(a - 1); chk("R4 decf", r, !d, d, r == 0, a[6], a[7], 0, 0, 8'h22);
      run({6'b001000, d, 7'h23}, w, 8'(a), ~a[0], ~a[6], ~a[7], 0);
      chk("R4 movf", 8'(a), !d, d, a == 0, ~a[6], ~a[7], 0, 0, 8'h23);
    end

    // R5: rotates through carry
    for (int a = 0; a < 256; a++) begin
      for (int ci = 0; ci < 2; ci++) begin
        d = a[0];
        run({6'b001101, d, 7'h30}, 8'h00, 8'(a), a[1], a[2], ci[0], 0);
        chk("R5 rlf", {8'(a) << 1} | 8'(ci), !d, d, a[1], a[2], a[7], 0, 0, 8'h30);
        run({6'b001100, d, 7'h31}, 8'h00, 8'(a), ~a[1], a[3], ci[0], 0);
        chk("R5 rrf", {ci[0], a[7:1]}, !d, d, ~a[1], a[3], a[0], 0, 0, 8'h31);
      end
    end

    // R6: swap and bit clear/set leave flags; bit number in opcode bits 9:7
    for (int a = 0; a < 256; a += 17) begin
      run({6'b001110, a[0], 7'h40}, 8'h00, 8'(a), a[1], a[2], a[3], 0);
      chk("R6 swapf", {a[3:0], a[7:4]}, !a[0], a[0], a[1], a[2], a[3], 0, 0, 8'h40);
      for (int b = 0; b < 8; b++) begin
        run({4'b0100, 3'(b), 7'h41}, 8'hFF, 8'(a), a[0], a[1], a[2], 1);
        chk("R6 bcf", 8'(a) & ~(8'd1 << b), 0, 1, a[0], a[1], a[2], 0, 0, 8'hC1);
        run({4'b0101, 3'(b), 7'h42}, 8'h00, 8'(a), ~a[0], a[1], ~a[2], 0);
        chk("R6 bsf", 8'(a) | (8'd1 << b), 0, 1, ~a[0], a[1], ~a[2], 0, 0, 8'h42);
      end
    end

    // R7: destination select by opcode bit 7 and bank-joined address
    for (int i = 0; i < 4; i++) begin
      run({6'b000100, i[0], 7'h7F}, 8'h0F, 8'hF0, 0, 0, 0, i[1]);
      chk("R7 dest/addr", 8'hFF, !i[0], i[0], 0, 0, 0, 0, 0, {i[1], 7'h7F});
    end

    // R8: clear forces zero
    run({7'b0000011, 7'h15}, 8'h55, 8'hAA, 0, 1, 1, 0);
    chk("R8 clrf", 8'h00, 0, 1, 1, 1, 1, 0, 0, 8'h15);
    run({7'b0000010, 7'h03}, 8'h55, 8'hAA, 0, 0, 1, 1);
    chk("R8 clrw", 8'h00, 1, 0, 1, 0, 1, 0, 0, 8'h83);

    // R9: bit tests
    run({6'b11000, 1'b0, 8'h5A}, 8'h00, 8'h00, 0, 0, 0, 0);
    chk("R11 movlw", 8'h5A, 1, 0, 0, 0, 0, 0, 0, 8'h5A);
    for (int a = 0; a < 256; a += 37) begin
      for (int b = 0; b < 8; b++) begin
        run({4'b0110, 3'(b), 7'h50}, 8'h00, 8'(a), a[0], a[1], a[2], 0);
        chk("R9 btfsc", last_res, 0, 0, a[0], a[1], a[2], !a[b], 0, 8'h50);
        run({4'b0111, 3'(b), 7'h51}, 8'h00, 8'(a), ~a[0], a[1], a[2], 0);
        chk("R9 btfss", last_res, 0, 0, ~a[0], a[1], a[2], a[b], 0, 8'h51);
      end
    end

    // R10: increment/decrement with skip
    for (int a = 0; a < 256; a++) begin
      d = a[0];
      run({6'b001111, d, 7'h60}, 8'h00, 8'(a), a[1], a[2], a[3], 0);
      chk("R10 incfsz", 8'(a + 1), !d, d, a[1], a[2], a[3], a == 255, 0, 8'h60);
      run({6'b001011, d, 7'h61}, 8'h00, 8'(a), ~a[1], a[2], ~a[3], 0);
      chk("R10 decfsz", 8'(a - 1), !d, d, ~a[1], a[2], ~a[3], a == 1, 0, 8'h61);
    end

    // R11: literal loads, move-to-file, inert codes
    run({6'b110101, 8'hC3}, 8'h11, 8'h22, 1, 0, 1, 0);
    chk("R11 retlw", 8'hC3, 1, 0, 1, 0, 1, 0, 0, 8'h43);
    run({7'b0000001, 7'h0C}, 8'h9E, 8'h22, 0, 1, 0, 1);
    chk("R11 movwf", 8'h9E, 0, 1, 0, 1, 0, 0, 0, 8'h8C);
    foreach (k[i]) begin end
    run(14'h0063, 8'h01, 8'h02, 1, 1, 0, 0);
    chk("R11 control", last_res, 0, 0, 1, 1, 0, 0, 0, 8'h63);
    run(14'h0000, 8'h01, 8'h02, 0, 1, 1, 0);
    chk("R11 nop", last_res, 0, 0, 0, 1, 1, 0, 0, 8'h00);
    run(14'h2ABC, 8'h01, 8'h02, 1, 0, 0, 1);
    chk("R11 call", last_res, 0, 0, 1, 0, 0, 0, 0, 8'hBC);

    // R12: undefined code holds everything, single-cycle pulse
    run({6'b11111, 1'b0, 8'h7F}, 8'h01, 8'h00, 0, 0, 0, 0);
    chk("R12 setup", 8'h80, 1, 0, 0, 1, 0, 0, 0, 8'h7F);
    run({6'b111011, 8'h7F}, 8'h01, 8'h00, 1, 0, 1, 0);
    chk("R12 bad", 8'h80, 0, 0, 1, 0, 1, 0, 1, 8'h7F);
    run(14'h0000, 8'h00, 8'h00, 0, 0, 0, 0);
    chk("R12 pulse end", 8'h80, 0, 0, 0, 0, 0, 0, 0, 8'h00);

    // R13: one-cycle latency, nothing visible before the edge
    opcode = {6'b11000, 1'b0, 8'h3C}; w_in = 8'h00;
    #9;
    checks++;
    if (res_q !== 8'h80) begin
      failures++;
      $display("FAIL R13 early: actual res=%h expected res=%h", res_q, 8'h80);
    end
    @(negedge clk);
    chk("R13 after edge", 8'h3C, 1, 0, 0, 0, 0, 0, 0, 8'h3C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule